// File: doc/BRIEF.md
# Serial Debug Link Target Controller

This block is the target end of a serial debug link between an external debug tool and a processor core. The tool shifts in frames of a fixed length. Each frame holds a start bit, a mode bit, a control bit and a 32-bit payload. The block decodes the frame into one of these actions: an instruction for the core, a data word for the core, a write of the trap-enable register, a port command, or no operation.

While a frame shifts in, the block shifts a status frame out on the serial output. That frame reports one of the following: a data word the core returned, a sequencing error, a pending interrupt, or nothing. All serial activity is paced by a one-cycle bit strobe on the system clock. The tool derives this strobe from its shift clock.

The serial output acts as a handshake. It is held low only while the core is waiting for an instruction or a data word. The tool starts a frame only after it has seen the output low.

Top module: `dbgp_link`

## Requirements
- R1: When no frame is in progress and the core requests neither an instruction nor data, `ser_out` is high. While the core requests either one, `ser_out` is low, and this low level is the ready bit of the next outgoing frame.
- R2: A high `ser_in` sampled on a bit strobe while the block is not ready does not start a frame. Such a frame has no effect on any output, and a later frame reports null status.
- R3: An incoming frame is 35 bits, shifted MSB first: start (1), mode, control, then payload bits 31 down to 0. Mode 0 with control 0 gives the payload to the core with a one-cycle `core_instr_vld`. Mode 0 with control 1 does the same with `core_data_vld`. The word is on `core_word`.
- R4: A mode-0 frame whose control bit disagrees with the request the core had when the frame started is discarded. No valid pulse is raised, and the next outgoing frame carries status code 01 (sequence error).
- R5: A mode-1 frame with control 0 loads the first seven payload bits (payload[31:25]) into `trap_en` at the end of the frame. The remaining payload bits are ignored, and `trap_en` changes at no other time.
- R6: A mode-1 frame with control 1 is a port command when payload[29:25] are all ones. Payload[31:30] then selects the command: 00 gives a one-cycle `brk_negate`, 01 gives a one-cycle `core_reset`, 10 sets `fast_dl`, and 11 clears `fast_dl`.
- R7: Any other mode-1, control-1 frame is a no-operation. It raises no pulse and changes neither `trap_en` nor `fast_dl`.
- R8: Each outgoing frame is a low ready bit, then a 2-bit status, then 32 data bits, all MSB first. The status codes are 00 valid data, 01 sequence error, 10 interrupt pending and 11 null. The data bits are zero for every status except 00.
- R9: A word returned by the core (`core_ret_vld`) outranks every other status. The order below it is sequence error, then interrupt. An interrupt that coincides with valid data is reported in the following frame.
- R10: Each pending condition is reported once, in the first frame that selects it, and is then cleared.
- R11: After reset, `trap_en` is 0, `fast_dl` is 0, no pulse output is high and no status is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| ser_in | input | 1 | Serial data from the tool |
| ser_out | output | 1 | Serial status and data to the tool |
| core_want_instr | input | 1 | Core is waiting for an instruction |
| core_want_data | input | 1 | Core is waiting for a data word |
| core_instr_vld | output | 1 | Instruction word delivered |
| core_data_vld | output | 1 | Data word delivered |
| core_word | output | 32 | Delivered word |
| core_ret_vld | input | 1 | Core loads a word into the debug data register |
| core_ret_data | input | 32 | Word returned by the core |
| irq_req | input | 1 | Interrupt recognised (pulse) |
| trap_en | output | 7 | Trap-enable register |
| brk_negate | output | 1 | Negate breakpoint requests (pulse) |
| core_reset | output | 1 | Core reset request (pulse) |
| fast_dl | output | 1 | Fast download active flag |

## Verification
A sequence of frames is sent that covers every decoded function. Matched instruction and data frames are separated from mismatched ones by whether a valid pulse appears and by the status in the next frame. Trap writes with junk in the low payload bits confirm that only seven bits are taken. Command codes with one tag bit cleared tell a real command apart from a no-operation.

Start bits sent while the core is idle show that an unready port ignores the tool. A returned word that arrives together with an interrupt shows the priority order and the carry-over to the next frame. A returned word queued behind a sequence error shows that valid data still goes out first.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [1:0] {
    ST_VALID  = 2'b00,
    ST_SEQERR = 2'b01,
    ST_IRQ    = 2'b10,
    ST_NULL   = 2'b11
  } dbg_stat_e;

  localparam int CODE_W = 7;
  localparam logic [4:0] CMD_TAG    = 5'b11111;
  localparam logic [1:0] CMD_BRK    = 2'b00;
  localparam logic [1:0] CMD_RST    = 2'b01;
  localparam logic [1:0] CMD_FDL_ON = 2'b10;
endpackage

// File: rtl/dbgp_shifter.sv
module dbgp_shifter #(
  parameter int DATA_W = 32,
  localparam int FRM_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ser_in,
  input  logic              ready,
  input  logic [1:0]        ld_stat,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ser_out,
  output logic              busy,
  output logic              start_acc,
  output logic              frm_done,
  output logic [FRM_W-1:0]  frm_word
);
  localparam int CNT_W = $clog2(FRM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRM_W - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FRM_W-2:0] in_q, in_d;
  logic [FRM_W-1:0] out_q, out_d;

  always_comb begin
    start_acc = !busy_q && bit_stb && ser_in && ready;
    frm_done  = busy_q && bit_stb && (cnt_q == LAST);
    frm_word  = {in_q, ser_in};
    ser_out   = busy_q ? out_q[FRM_W-1] : !ready;
    busy      = busy_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    in_d   = in_q;
    out_d  = out_q;
    if (start_acc) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      out_d  = {ld_stat, ld_data};
    end else if (busy_q && bit_stb) begin
      in_d  = {in_q[FRM_W-3:0], ser_in};
      out_d = {out_q[FRM_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      in_q   <= '0;
      out_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      in_q   <= in_d;
      out_q  <= out_d;
    end
  end

  assert_start_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ready));
endmodule

// File: rtl/dbgp_status.sv
module dbgp_status
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_vld,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              irq,
  input  logic              seq_set,
  input  logic              take,
  output logic [1:0]        stat,
  output logic [DATA_W-1:0] stat_data
);
  logic              full_q, full_d;
  logic              seq_q, seq_d;
  logic              irq_q, irq_d;
  logic [DATA_W-1:0] dreg_q, dreg_d;

  always_comb begin
    stat_data = '0;
    if (full_q) begin
      stat      = ST_VALID;
      stat_data = dreg_q;
    end else if (seq_q) begin
      stat = ST_SEQERR;
    end else if (irq_q) begin
      stat = ST_IRQ;
    end else begin
      stat = ST_NULL;
    end
    full_d = ret_vld ? 1'b1 : (take && full_q) ? 1'b0 : full_q;
    seq_d  = seq_set ? 1'b1 : (take && !full_q && seq_q) ? 1'b0 : seq_q;
    irq_d  = irq ? 1'b1 : (take && !full_q && !seq_q && irq_q) ? 1'b0 : irq_q;
    dreg_d = ret_vld ? ret_data : dreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      seq_q  <= 1'b0;
      irq_q  <= 1'b0;
      dreg_q <= '0;
    end else begin
      full_q <= full_d;
      seq_q  <= seq_d;
      irq_q  <= irq_d;
      dreg_q <= dreg_d;
    end
  end

  assert_irq_held_over_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take && full_q && irq_q |=> irq_q);
  assert_irq_reported_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take && !full_q && !seq_q && irq_q && !irq |=> !irq_q);
endmodule

// File: rtl/dbgp_decode.sv
module dbgp_decode
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int FRM_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [FRM_W-1:0]  frm_word,
  input  logic              exp_data,
  output logic              instr_vld,
  output logic              data_vld,
  output logic [DATA_W-1:0] word,
  output logic [CODE_W-1:0] trap_en,
  output logic              brk_neg,
  output logic              core_rst,
  output logic              fdl,
  output logic              seq_set
);
  logic              mode, ctrl;
  logic [DATA_W-1:0] payload;
  logic [CODE_W-1:0] code;
  logic ivld_d, dvld_d, brk_d, rst_d, seq_d, fdl_d;
  logic [DATA_W-1:0] word_d;
  logic [CODE_W-1:0] trap_d;

  always_comb begin
    mode    = frm_word[FRM_W-1];
    ctrl    = frm_word[FRM_W-2];
    payload = frm_word[DATA_W-1:0];
    code    = payload[DATA_W-1 -: CODE_W];
    ivld_d = 1'b0;
    dvld_d = 1'b0;
    brk_d  = 1'b0;
    rst_d  = 1'b0;
    seq_d  = 1'b0;
    word_d = word;
    trap_d = trap_en;
    fdl_d  = fdl;
    if (frm_done) begin
      if (!mode) begin
        if (ctrl == exp_data) begin
          word_d = payload;
          if (ctrl) dvld_d = 1'b1;
          else      ivld_d = 1'b1;
        end else begin
          seq_d = 1'b1;
        end
      end else if (!ctrl) begin
        trap_d = code;
      end else if (code[4:0] == CMD_TAG) begin
        case (code[CODE_W-1 -: 2])
          CMD_BRK:    brk_d = 1'b1;
          CMD_RST:    rst_d = 1'b1;
          CMD_FDL_ON: fdl_d = 1'b1;
          default:    fdl_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_vld <= 1'b0;
      data_vld  <= 1'b0;
      word      <= '0;
      trap_en   <= '0;
      brk_neg   <= 1'b0;
      core_rst  <= 1'b0;
      fdl       <= 1'b0;
      seq_set   <= 1'b0;
    end else begin
      instr_vld <= ivld_d;
      data_vld  <= dvld_d;
      word      <= word_d;
      trap_en   <= trap_d;
      brk_neg   <= brk_d;
      core_rst  <= rst_d;
      fdl       <= fdl_d;
      seq_set   <= seq_d;
    end
  end

  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_vld, data_vld, brk_neg, core_rst, seq_set}));
  assert_trap_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |=> $stable(trap_en));
  assert_reset_pulse_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);
endmodule

// File: rtl/dbgp_link.sv
module dbgp_link
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              core_want_instr,
  input  logic              core_want_data,
  output logic              core_instr_vld,
  output logic              core_data_vld,
  output logic [DATA_W-1:0] core_word,
  input  logic              core_ret_vld,
  input  logic [DATA_W-1:0] core_ret_data,
  input  logic              irq_req,
  output logic [CODE_W-1:0] trap_en,
  output logic              brk_negate,
  output logic              core_reset,
  output logic              fast_dl
);
  localparam int FRM_W = DATA_W + 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_int;
  logic              ready, busy, start_acc, frm_done, seq_set;
  logic              exp_data_q, exp_data_d;
  logic [FRM_W-1:0]  frm_word;
  logic [1:0]        stat;
  logic [DATA_W-1:0] stat_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int = rst_pipe_q[1];

  always_comb begin
    ready      = (core_want_instr || core_want_data) && !busy
                 && !core_instr_vld && !core_data_vld;
    exp_data_d = start_acc ? (core_want_data && !core_want_instr) : exp_data_q;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) exp_data_q <= 1'b0;
    else          exp_data_q <= exp_data_d;
  end

  dbgp_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_int), .bit_stb(bit_stb), .ser_in(ser_in),
    .ready(ready), .ld_stat(stat), .ld_data(stat_data), .ser_out(ser_out),
    .busy(busy), .start_acc(start_acc), .frm_done(frm_done), .frm_word(frm_word)
  );

  dbgp_status #(.DATA_W(DATA_W)) i_stat (
    .clk(clk), .rst_n(rst_int), .ret_vld(core_ret_vld), .ret_data(core_ret_data),
    .irq(irq_req), .seq_set(seq_set), .take(start_acc), .stat(stat),
    .stat_data(stat_data)
  );

  dbgp_decode #(.DATA_W(DATA_W)) i_dec (
    .clk(clk), .rst_n(rst_int), .frm_done(frm_done), .frm_word(frm_word),
    .exp_data(exp_data_q), .instr_vld(core_instr_vld), .data_vld(core_data_vld),
    .word(core_word), .trap_en(trap_en), .brk_neg(brk_negate),
    .core_rst(core_reset), .fdl(fast_dl), .seq_set(seq_set)
  );

  assert_idle_output_high_R1: assert property (@(posedge clk) disable iff (!rst_int)
    !busy && !core_want_instr && !core_want_data |-> ser_out);
  assert_mismatch_discarded_R4: assert property (@(posedge clk) disable iff (!rst_int)
    frm_done && !frm_word[FRM_W-1] && (frm_word[FRM_W-2] != exp_data_q)
    |=> !core_instr_vld && !core_data_vld);
endmodule

// File: tb/test_dbgp_link.sv
module test_dbgp_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_stb = 1'b0, ser_in = 1'b0;
  logic        ser_out;
  logic        want_i = 1'b0, want_d = 1'b0;
  logic        ivld, dvld, brk, crst, fdl;
  logic [31:0] word;
  logic        ret_vld = 1'b0;
  logic [31:0] ret_data = '0;
  logic        irq = 1'b0;
  logic [6:0]  trap;

  int n_chk = 0, n_bad = 0;
  int c_i = 0, c_d = 0, c_b = 0, c_r = 0;
  logic [31:0] last_word = '0;

  always #10 clk = ~clk;

  dbgp_link i_dbgp_link (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ser_in(ser_in), .ser_out(ser_out),
    .core_want_instr(want_i), .core_want_data(want_d), .core_instr_vld(ivld),
    .core_data_vld(dvld), .core_word(word), .core_ret_vld(ret_vld),
    .core_ret_data(ret_data), .irq_req(irq), .trap_en(trap), .brk_negate(brk),
    .core_reset(crst), .fast_dl(fdl)
  );

  always @(negedge clk) begin
    if (ivld) begin c_i <= c_i + 1; last_word <= word; end
    if (dvld) begin c_d <= c_d + 1; last_word <= word; end
    if (brk)  c_b <= c_b + 1;
    if (crst) c_r <= c_r + 1;
  end

  // vector: want_data, mode, ctrl, payload, event(0 none,1 instr,2 data,3 brk,4 rst), trap, fdl, status seen
  localparam logic [47:0] VEC [0:11] = '{
    {1'b0, 1'b0, 1'b0, 32'hA5A50F0F,            3'd1, 7'h00, 1'b0, 2'b11},
    {1'b1, 1'b0, 1'b1, 32'h12345678,            3'd2, 7'h00, 1'b0, 2'b11},
    {1'b0, 1'b0, 1'b1, 32'h0BADF00D,            3'd0, 7'h00, 1'b0, 2'b11},
    {1'b0, 1'b1, 1'b1, 32'h00000000,            3'd0, 7'h00, 1'b0, 2'b01},
    {1'b0, 1'b1, 1'b0, {7'h55, 25'h0123456},    3'd0, 7'h55, 1'b0, 2'b11},
    {1'b1, 1'b0, 1'b0, 32'h77777777,            3'd0, 7'h55, 1'b0, 2'b11},
    {1'b1, 1'b1, 1'b1, {7'b1011111, 25'h0},     3'd0, 7'h55, 1'b1, 2'b01},
    {1'b0, 1'b1, 1'b1, {7'b0011111, 25'h1},     3'd3, 7'h55, 1'b1, 2'b11},
    {1'b0, 1'b1, 1'b1, {7'b0111111, 25'h0},     3'd4, 7'h55, 1'b1, 2'b11},
    {1'b0, 1'b1, 1'b1, {7'b1111111, 25'h0},     3'd0, 7'h55, 1'b0, 2'b11},
    {1'b0, 1'b1, 1'b1, {7'b0011110, 25'h0},     3'd0, 7'h55, 1'b0, 2'b11},
    {1'b1, 1'b0, 1'b1, 32'hFFFF0001,            3'd2, 7'h55, 1'b0, 2'b11}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic mode, input logic ctrl, input logic [31:0] pl,
                            output logic [34:0] rx);
    logic [34:0] tx;
    tx = {1'b1, mode, ctrl, pl};
    for (int i = 34; i >= 0; i--) begin
      @(negedge clk);
      rx[i]   = ser_out;
      ser_in  = tx[i];
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ret(input logic [31:0] d, input logic with_irq);
    @(negedge clk);
    ret_vld = 1'b1; ret_data = d; irq = with_irq;
    @(negedge clk);
    ret_vld = 1'b0; irq = 1'b0;
  endtask

  function automatic int evt_of(input int i0, d0, b0, r0, i1, d1, b1, r1);
    if (i1 != i0) return 1;
    if (d1 != d0) return 2;
    if (b1 != b0) return 3;
    if (r1 != r0) return 4;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic [34:0] rx;
    int i0, d0, b0, r0, ev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state, R1 idle output
    chk(ser_out === 1'b1, "R1 idle high", ser_out, 1);
    chk(trap === 7'h0, "R11 trap reset", trap, 0);
    chk(fdl === 1'b0, "R11 fast_dl reset", fdl, 0);
    chk({ivld, dvld, brk, crst} === 4'b0, "R11 pulses low", {ivld, dvld, brk, crst}, 0);

    // vector walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 12; v++) begin
      logic [47:0] e;
      e = VEC[v];
      want_d = e[47]; want_i = !e[47];
      @(negedge clk);
      i0 = c_i; d0 = c_d; b0 = c_b; r0 = c_r;
      send_frame(e[46], e[45], e[44:13], rx);
      ev = evt_of(i0, d0, b0, r0, c_i, c_d, c_b, c_r);
      chk(rx[34] === 1'b0, "R1 ready bit", rx[34], 0);
      chk(ev == int'(e[12:10]), "R3/R6/R7 event", ev, e[12:10]);
      if (ev == 1 || ev == 2) chk(last_word === e[44:13], "R3 word", last_word, e[44:13]);
      chk(trap === e[9:3], "R5 trap_en", trap, e[9:3]);
      chk(fdl === e[2], "R6 fast_dl", fdl, e[2]);
      chk(rx[33:32] === e[1:0], "R4/R8 status", rx[33:32], e[1:0]);
      chk(rx[31:0] === 32'h0, "R8 data zero", rx[31:0], 0);
      if (ev == 4) chk(c_r - r0 == 1, "R6 reset one cycle", c_r - r0, 1);
      want_i = 1'b0; want_d = 1'b0;
    end

    // R2: start bits while not ready
    @(negedge clk);
    i0 = c_i; d0 = c_d; b0 = c_b; r0 = c_r;
    send_frame(1'b0, 1'b0, 32'hDEADBEEF, rx);
    chk(rx === {35{1'b1}}, "R2 output stays high", rx, {35{1'b1}});
    ev = evt_of(i0, d0, b0, r0, c_i, c_d, c_b, c_r);
    chk(ev == 0, "R2 no event", ev, 0);
    want_i = 1'b1;
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b11, "R2 later status null", rx[33:32], 3);

    // R9 valid data beats coincident interrupt; R10 reported once
    pulse_ret(32'hCAFEBABE, 1'b1);
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b00, "R9 valid first", rx[33:32], 0);
    chk(rx[31:0] === 32'hCAFEBABE, "R8 valid data bits", rx[31:0], 32'hCAFEBABE);
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b10, "R9 irq held over", rx[33:32], 2);
    chk(rx[31:0] === 32'h0, "R8 irq data zero", rx[31:0], 0);
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b11, "R10 cleared", rx[33:32], 3);

    // R9 valid data beats pending sequence error
    send_frame(1'b0, 1'b1, 32'h11112222, rx);
    pulse_ret(32'h000000FF, 1'b0);
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b00, "R9 valid over seqerr", rx[33:32], 0);
    chk(rx[31:0] === 32'hFF, "R9 data", rx[31:0], 32'hFF);
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b01, "R4 seqerr after valid", rx[33:32], 1);
    send_frame(1'b1, 1'b1, 32'h0, rx);
    chk(rx[33:32] === 2'b11, "R10 seqerr once", rx[33:32], 3);

    // R1 output follows request
    want_i = 1'b0;
    @(negedge clk);
    chk(ser_out === 1'b1, "R1 high without request", ser_out, 1);
    want_d = 1'b1;
    @(negedge clk);
    chk(ser_out === 1'b0, "R1 low with request", ser_out, 0);
    want_d = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule